// File: doc/BRIEF.md
# SPI Transmit Zero-Fill Controller

This block sits next to the transmit and receive byte FIFOs of an SPI master. Software loads a byte count into a transfer-size register. While a transfer is under way, the block then pushes 4-byte words of zeros into the transmit FIFO. The peripheral can therefore clock that many bytes back without software writing any dummy data. The block never fills the transmit FIFO so far that the bytes it has queued could overrun the receive FIFO. Before each push it checks the combined occupancy of both FIFOs against a receive-almost-full headroom limit.

The block also decides when the transmit FIFO should drain. In automatic mode, draining starts as soon as the transmit FIFO holds data. In manual mode, draining waits for a start request. That request is remembered until the transmit FIFO is empty and the transfer count has run out. A push-wait option in the command register holds off zero filling while software data is still queued. At most one zero word is pushed per clock cycle, and the count is reduced in the same cycle as the push.

Top module: `txfill_ctrl`

## Requirements
- R1: No push occurs in any cycle in which the registered transfer size (`size_left`) is zero.
- R2: While the push-wait flag (command write, bit 0) is set and `tx_count` is nonzero, no push occurs. Once `tx_count` is zero, pushing may resume.
- R3: `push_zero` is a strobe meaning one 4-byte zero word for the transmit FIFO. It is asserted for one cycle per word, at most one word per cycle. It can assert only while `drain_req` is high.
- R4: On each push without a simultaneous size write, the next `size_left` is computed in two steps. First the current value has its two low bits cleared. Then 4 is subtracted, saturating at zero. So 12 becomes 8, 7 becomes 0, and 3 becomes 0.
- R5: A push occurs only when `rx_count + tx_count` is below `RX_AFULL - 3` (61 by default). A sum of 61 blocks pushing and a sum of 60 allows it.
- R6: A config write (`wr_sel`=0) latches a manual start (`start_pend`) only when its bit 16 is set and manual-start-enable was already 1 before that write. Bit 15 of the config write sets manual-start-enable. The start bit itself is not retained.
- R7: `drain_req` equals `start_pend OR (tx_count != 0 AND manual-start-enable == 0)`. Pushing happens only under `drain_req`.
- R8: `start_pend` clears on the clock edge of a cycle in which `tx_count` is zero and `size_left` is zero, unless a new start is latched in that cycle.
- R9: A write with `wr_sel`=2 replaces the transfer size on the next edge and takes priority over the decrement. Writing zero stops pushing from the next cycle.
- R10: After reset, `size_left`, `start_pend`, `push_zero` and `drain_req` are all zero, and manual-start-enable and push-wait are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 config, 1 command, 2 transfer size |
| wr_data | input | 32 | Write data |
| tx_count | input | CNT_W | Transmit FIFO occupancy in bytes |
| rx_count | input | CNT_W | Receive FIFO occupancy in bytes |
| push_zero | output | 1 | Push one 4-byte zero word into the transmit FIFO |
| drain_req | output | 1 | Request to start or continue draining the transmit FIFO |
| size_left | output | 32 | Remaining transfer size in bytes |
| start_pend | output | 1 | Latched manual start request |

## Verification
`push_zero` and `drain_req` are combinational in the same cycle from the registered state and the current FIFO counts. `size_left` and `start_pend` show the effect of a write, push or clear one clock edge later. The driver applies each cycle's inputs just after a rising edge and queues that cycle's expected outputs. The monitor compares them at the following falling edge, before the edge that registers the update. A write or push is therefore seen in `size_left` in the next queued item, never in the same one.

// File: rtl/txfill_pkg.sv
package txfill_pkg;

    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_SIZE = 2'd2;

    localparam int CFG_MEN_BIT   = 15;
    localparam int CFG_START_BIT = 16;
    localparam int CMD_WAIT_BIT  = 0;

    typedef struct packed {
        logic man_en;
        logic push_wait;
        logic pend;
    } ctl_state_t;

    typedef struct packed {
        logic [31:0] size;
    } pump_state_t;

endpackage

// File: rtl/txfill_regs.sv
module txfill_regs
    import txfill_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        tx_empty,
    input  logic        size_zero,
    output logic        man_en,
    output logic        push_wait,
    output logic        pend
);

    ctl_state_t st_d, st_q;
    logic       cfg_wr;
    logic       start_hit;

    always_comb begin
        st_d      = st_q;
        cfg_wr    = wr_en && (wr_sel == SEL_CFG);
        start_hit = cfg_wr && wr_data[CFG_START_BIT] && st_q.man_en;

        if (cfg_wr) begin
            st_d.man_en = wr_data[CFG_MEN_BIT];
        end
        if (wr_en && (wr_sel == SEL_CMD)) begin
            st_d.push_wait = wr_data[CMD_WAIT_BIT];
        end

        if (start_hit) begin
            st_d.pend = 1'b1;
        end else if (tx_empty && size_zero) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign man_en    = st_q.man_en;
    assign push_wait = st_q.push_wait;
    assign pend      = st_q.pend;

endmodule

// File: rtl/txfill_pump.sv
module txfill_pump
    import txfill_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RX_AFULL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             size_wr,
    input  logic [31:0]      size_wdata,
    input  logic             trigger,
    input  logic             push_wait,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output logic             push,
    output logic [31:0]      size
);

    localparam int SUM_W = CNT_W + 1;
    localparam int LIMIT = RX_AFULL - 3;
    localparam logic [SUM_W-1:0] LIMIT_V = SUM_W'(LIMIT);

    pump_state_t       st_d, st_q;
    logic [SUM_W-1:0]  occ_sum;
    logic              room_ok;
    logic              wait_blk;
    logic [31:0]       rounded;

    always_comb begin
        st_d     = st_q;
        occ_sum  = SUM_W'(tx_count) + SUM_W'(rx_count);
        room_ok  = occ_sum < LIMIT_V;
        wait_blk = push_wait && (tx_count != '0);
        push     = trigger && (st_q.size != 32'd0) && !wait_blk && room_ok;
        rounded  = st_q.size & ~32'd3;

        if (size_wr) begin
            st_d.size = size_wdata;
        end else if (push) begin
            st_d.size = (rounded >= 32'd4) ? (rounded - 32'd4) : 32'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign size = st_q.size;

endmodule

// File: rtl/txfill_ctrl.sv
module txfill_ctrl
    import txfill_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int RX_AFULL   = 64,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output logic             push_zero,
    output logic             drain_req,
    output logic [31:0]      size_left,
    output logic             start_pend
);

    logic man_en_w;
    logic push_wait_w;
    logic pend_w;
    logic trigger_w;
    logic size_wr_w;
    logic tx_empty_w;

    assign tx_empty_w = (tx_count == '0);
    assign size_wr_w  = wr_en && (wr_sel == SEL_SIZE);

    txfill_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .tx_empty  (tx_empty_w),
        .size_zero (size_left == 32'd0),
        .man_en    (man_en_w),
        .push_wait (push_wait_w),
        .pend      (pend_w)
    );

    assign trigger_w = pend_w || (!tx_empty_w && !man_en_w);

    txfill_pump #(
        .CNT_W    (CNT_W),
        .RX_AFULL (RX_AFULL)
    ) u_pump (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_wr    (size_wr_w),
        .size_wdata (wr_data),
        .trigger    (trigger_w),
        .push_wait  (push_wait_w),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .push       (push_zero),
        .size       (size_left)
    );

    assign drain_req  = trigger_w;
    assign start_pend = pend_w;

endmodule

// File: rtl/txfill_chk.sv
module txfill_chk
    import txfill_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RX_AFULL = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [31:0]      wr_data,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             push_zero,
    input logic             drain_req,
    input logic [31:0]      size_left,
    input logic             start_pend,
    input logic             man_en,
    input logic             push_wait
);

    logic size_wr;
    logic start_wr;
    assign size_wr  = wr_en && (wr_sel == SEL_SIZE);
    assign start_wr = wr_en && (wr_sel == SEL_CFG) && wr_data[CFG_START_BIT] && man_en;

    p_no_push_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (size_left == 32'd0) |-> !push_zero);

    p_wait_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_wait && (tx_count != '0)) |-> !push_zero);

    p_push_needs_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_zero |-> drain_req);

    p_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_zero && !size_wr) |=> (size_left < $past(size_left)) && (size_left[1:0] == 2'b00));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_zero |-> ((32'(tx_count) + 32'(rx_count)) < 32'(RX_AFULL - 3)));

    p_latch_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pend) |-> $past(start_wr));

    p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pend && (tx_count == '0) && (size_left == 32'd0) && !start_wr) |=> !start_pend);

    p_size_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        size_wr |=> (size_left == $past(wr_data)));

endmodule

bind txfill_ctrl txfill_chk #(
    .CNT_W    (CNT_W),
    .RX_AFULL (RX_AFULL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .push_zero  (push_zero),
    .drain_req  (drain_req),
    .size_left  (size_left),
    .start_pend (start_pend),
    .man_en     (man_en_w),
    .push_wait  (push_wait_w)
);

// File: tb/txfill_ctrl_tb.sv
module txfill_ctrl_tb;

    localparam int CNT_W = 8;
    localparam logic [31:0] CFG_EN       = 32'h0000_8000;
    localparam logic [31:0] CFG_EN_START = 32'h0001_8000;

    typedef struct packed {
        logic        push;
        logic        drain;
        logic [31:0] size;
        logic        pend;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [31:0]      wr_data = 32'd0;
    logic [CNT_W-1:0] tx_count = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             push_zero;
    logic             drain_req;
    logic [31:0]      size_left;
    logic             start_pend;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    txfill_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .push_zero  (push_zero),
        .drain_req  (drain_req),
        .size_left  (size_left),
        .start_pend (start_pend)
    );

    // Monitor: compares one queued expectation per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (push_zero !== e.push || drain_req !== e.drain ||
                size_left !== e.size || start_pend !== e.pend) begin
                n_fail++;
                $display("FAIL %s: push=%0b drain=%0b size=%0d pend=%0b expected push=%0b drain=%0b size=%0d pend=%0b",
                         t, push_zero, drain_req, size_left, start_pend,
                         e.push, e.drain, e.size, e.pend);
            end
        end
    end

    // Driver: one cycle of inputs plus that cycle's expected outputs
    task automatic step(input string t, input logic we, input logic [1:0] sel,
                        input logic [31:0] data, input int tx, input int rx,
                        input logic ep, input logic ed, input int es, input logic epd);
        exp_t e;
        @(posedge clk);
        #1;
        wr_en    = we;
        wr_sel   = sel;
        wr_data  = data;
        tx_count = CNT_W'(tx);
        rx_count = CNT_W'(rx);
        e.push  = ep;
        e.drain = ed;
        e.size  = 32'(es);
        e.pend  = epd;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        step("R10 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9 size load seen next cycle; R7 empty tx in auto mode gives no drain
        step("R9 load 12", 1, 2, 12, 0, 0, 0, 0, 0, 0);
        step("R7 idle auto", 0, 0, 0, 0, 0, 0, 0, 12, 0);
        // R3 one word per cycle, R4 decrement
        step("R3 push 12", 0, 0, 0, 4, 0, 1, 1, 12, 0);
        step("R4 push 8", 0, 0, 0, 4, 0, 1, 1, 8, 0);
        step("R4 push 4", 0, 0, 0, 4, 0, 1, 1, 4, 0);
        step("R1 size zero", 0, 0, 0, 4, 0, 0, 1, 0, 0);
        // R5 headroom: 61 blocks, 60 allows
        step("R5 load 8", 1, 2, 8, 4, 57, 0, 1, 0, 0);
        step("R5 sum 61", 0, 0, 0, 4, 57, 0, 1, 8, 0);
        step("R5 sum 60", 0, 0, 0, 4, 56, 1, 1, 8, 0);
        // R9 zero write replaces remaining count
        step("R9 write zero", 1, 2, 0, 4, 0, 1, 1, 4, 0);
        step("R9 stopped", 0, 0, 0, 4, 0, 0, 1, 0, 0);
        // R4 rounding
        step("R4 load 7", 1, 2, 7, 4, 0, 0, 1, 0, 0);
        step("R4 push 7", 0, 0, 0, 4, 0, 1, 1, 7, 0);
        step("R4 7 to 0", 0, 0, 0, 4, 0, 0, 1, 0, 0);
        step("R4 load 3", 1, 2, 3, 4, 0, 0, 1, 0, 0);
        step("R4 push 3", 0, 0, 0, 4, 0, 1, 1, 3, 0);
        step("R4 3 to 0", 0, 0, 0, 4, 0, 0, 1, 0, 0);
        // R6 start with enable set in same write is not latched
        step("R6 en+start", 1, 0, CFG_EN_START, 0, 0, 0, 0, 0, 0);
        step("R6 no latch", 0, 0, 0, 4, 0, 0, 0, 0, 0);
        step("R7 load 8", 1, 2, 8, 4, 0, 0, 0, 0, 0);
        step("R7 manual hold", 0, 0, 0, 4, 0, 0, 0, 8, 0);
        step("R2 set wait", 1, 1, 1, 4, 0, 0, 0, 8, 0);
        step("R6 start", 1, 0, CFG_EN_START, 4, 0, 0, 0, 8, 0);
        step("R2 blocked", 0, 0, 0, 4, 0, 0, 1, 8, 1);
        step("R2 resume", 0, 0, 0, 0, 0, 1, 1, 8, 1);
        step("R8 hold size", 0, 0, 0, 0, 0, 1, 1, 4, 1);
        step("R8 hold tx", 0, 0, 0, 4, 0, 0, 1, 0, 1);
        step("R8 clear edge", 0, 0, 0, 0, 0, 0, 1, 0, 1);
        step("R8 cleared", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R6 not kept", 0, 0, 0, 4, 0, 0, 0, 0, 0);
        step("R6 en only", 1, 0, CFG_EN, 4, 0, 0, 0, 0, 0);
        step("R6 bit off", 0, 0, 0, 4, 0, 0, 0, 0, 0);

        @(posedge clk);
        #1 wr_en = 1'b0;
        @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule